// File: doc/BRIEF.md
# Clock Domain Transition Controller

This block governs a single clock domain on behalf of software. Software writes a 32-bit control word whose two lowest bits choose the transition behaviour of the domain: leave it as it is, put it to sleep, or force it awake. The same word, read back, carries one activity bit per gated clock of the domain, starting at bit 4.

A forced wakeup does not turn every clock on at once. Each gated clock has its own start-up delay, counted in cycles from the write, and its activity bit rises at that moment. Software therefore polls each bit on its own before it touches the domain. A forced sleep waits until every member module has acknowledged idle and none asks to keep its clock. Only then are all gate enables dropped together. The gate enables are ordinary logic outputs.

Top module: `cdtc_top`

## Requirements
- R1: After reset, every gate enable is 0 and the control word reads 0, so the domain is asleep with the transition field at the hold value.
- R2: The transition field is bits [1:0] and reads back the last value written, with 0 meaning hold, 1 meaning forced sleep and 2 meaning forced wakeup. A write of 3 is ignored and leaves the field unchanged.
- R3: Writes to bits [31:2] have no effect. In particular, the activity bits cannot be set or cleared by a write.
- R4: Write 2 to the field at clock edge t. Gate enable i, and its activity bit, then rise at edge t+D[i], where D is the per-clock delay parameter, with defaults 3, 7 and 12 for clocks 0, 1 and 2. The delay count starts again from zero each time the field is written to 2 from another value.
- R5: Activity bit 4+i always equals gate enable i.
- R6: While the field holds 1, all gate enables drop together at the first edge at which every idle acknowledge is 1 and no keep request is 1.
- R7: While any keep request is 1, or any idle acknowledge is 0, a forced sleep leaves every gate enable unchanged.
- R8: While the field holds 0, the gate enables keep their current values. This includes a wakeup cut short part way through.
- R9: Read bits other than [1:0] and the activity bits are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Value written to the control word |
| idle_ack | input | N_MOD | Per-module idle acknowledge |
| keep_req | input | N_MOD | Per-module request to keep the clock running |
| gate_en | output | N_CLK | Per-clock gate enable |
| rd_data | output | 32 | Control word read value |

## Verification
A stuck or wrongly reloaded delay counter would show at the ports as an activity bit that rises one or more cycles early or late. The bench therefore samples every bit at every cycle of a wakeup, and any error shows within at most 12 cycles of the write. A wrong sleep qualification would show in the cycle right after the inputs change: the enables drop while a keep request is present, or stay on once all modules are idle. A transition field that takes a reserved or out-of-field write shows in the next read value.

// File: rtl/cdtc_pkg.sv
package cdtc_pkg;

  // transition-field encodings
  typedef enum logic [1:0] {
    TC_HOLD  = 2'd0,
    TC_SLEEP = 2'd1,
    TC_WAKE  = 2'd2,
    TC_RSVD  = 2'd3
  } tc_mode_e;

  localparam int unsigned STAT_LSB = 4;
  localparam int unsigned DLY_W    = 8;
  localparam int unsigned MAX_CLK  = 8;

  // delay of clock i from a packed byte vector (clock 0 in the low byte)
  function automatic int unsigned dly_at(input logic [MAX_CLK*DLY_W-1:0] v, input int unsigned i);
    return int'(v[i*DLY_W +: DLY_W]);
  endfunction

  // largest delay among the first n clocks
  function automatic int unsigned dly_max(input logic [MAX_CLK*DLY_W-1:0] v, input int unsigned n);
    int unsigned m;
    m = 1;
    for (int unsigned k = 0; k < n; k++) begin
      if (dly_at(v, k) > m) m = dly_at(v, k);
    end
    return m;
  endfunction

  // counter width able to hold value m
  function automatic int unsigned cnt_bits(input int unsigned m);
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // read word assembly
  function automatic logic [31:0] pack_read(input tc_mode_e mode, input logic [MAX_CLK-1:0] act);
    logic [31:0] w;
    w = '0;
    w[1:0] = mode;
    w[STAT_LSB +: MAX_CLK] = act;
    return w;
  endfunction

endpackage

// File: rtl/cdtc_mode_reg.sv
module cdtc_mode_reg
  import cdtc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic [1:0] wr_field,
  output tc_mode_e mode_o
);

  tc_mode_e mode_q;
  logic     take_wr;

  assign take_wr = wr_en && (wr_field != TC_RSVD);

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= TC_HOLD;
    else if (take_wr) mode_q <= tc_mode_e'(wr_field);
  end

  assign mode_o = mode_q;

  // R2: reserved code never lands in the field
  assert_rsvd_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field == TC_RSVD) |=> $stable(mode_o));

  assert_field_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field != TC_RSVD) |=> (mode_o == $past(wr_field)));

endmodule

// File: rtl/cdtc_sleep_qual.sv
module cdtc_sleep_qual
  import cdtc_pkg::*;
#(
  parameter int unsigned N_MOD = 4
)(
  input  tc_mode_e           mode_i,
  input  logic [N_MOD-1:0]   idle_ack_i,
  input  logic [N_MOD-1:0]   keep_req_i,
  output logic               sleep_go_o
);

  logic all_idle;
  logic any_keep;

  assign all_idle   = &idle_ack_i;
  assign any_keep   = |keep_req_i;
  assign sleep_go_o = (mode_i == TC_SLEEP) && all_idle && !any_keep;

endmodule

// File: rtl/cdtc_wake_seq.sv
module cdtc_wake_seq
  import cdtc_pkg::*;
#(
  parameter int unsigned N_CLK = 3,
  parameter logic [MAX_CLK*DLY_W-1:0] DLY_VEC = 64'h0C_07_03
)(
  input  logic             clk,
  input  logic             rst_n,
  input  tc_mode_e         mode_i,
  input  logic             sleep_go_i,
  output logic [N_CLK-1:0] active_o
);

  localparam int unsigned MAXD = dly_max(DLY_VEC, N_CLK);
  localparam int unsigned CW   = cnt_bits(MAXD);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             wake_on;
  logic             cnt_sat;
  logic [N_CLK-1:0] wake_hit;
  logic [N_CLK-1:0] active_q;

  assign wake_on = (mode_i == TC_WAKE);
  assign cnt_sat = (cnt_q == CW'(MAXD));

  always_comb begin
    if (!wake_on)     cnt_d = '0;
    else if (cnt_sat) cnt_d = cnt_q;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < N_CLK; i++) begin : g_clk
    localparam int unsigned DLY_I = dly_at(DLY_VEC, i);

    assign wake_hit[i] = wake_on && (32'(cnt_d) >= DLY_I);

    always_ff @(posedge clk) begin
      if (!rst_n)           active_q[i] <= 1'b0;
      else if (sleep_go_i)  active_q[i] <= 1'b0;
      else if (wake_hit[i]) active_q[i] <= 1'b1;
    end

    // R4: a clock only turns on under a wakeup request
    assert_rise_needs_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q[i]) |-> ($past(mode_i) == TC_WAKE));
  end

  assign active_o = active_q;

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= MAXD);

  // R6: a qualified sleep clears every clock
  assert_sleep_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep_go_i) |-> (active_q == '0));

  // R7: no clock drops without a qualified sleep
  assert_no_drop_unqualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(active_q) & ~active_q)) |-> $past(sleep_go_i));

endmodule

// File: rtl/cdtc_top.sv
module cdtc_top
  import cdtc_pkg::*;
#(
  parameter int unsigned N_CLK = 3,
  parameter int unsigned N_MOD = 4,
  parameter logic [MAX_CLK*DLY_W-1:0] DLY_VEC = 64'h0C_07_03
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic [N_MOD-1:0] idle_ack,
  input  logic [N_MOD-1:0] keep_req,
  output logic [N_CLK-1:0] gate_en,
  output logic [31:0]      rd_data
);

  tc_mode_e         mode;
  logic             sleep_go;
  logic [N_CLK-1:0] active;
  logic [MAX_CLK-1:0] act_wide;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^wr_data[31:2];

  cdtc_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_field (wr_data[1:0]),
    .mode_o   (mode)
  );

  cdtc_sleep_qual #(.N_MOD(N_MOD)) u_qual (
    .mode_i     (mode),
    .idle_ack_i (idle_ack),
    .keep_req_i (keep_req),
    .sleep_go_o (sleep_go)
  );

  cdtc_wake_seq #(.N_CLK(N_CLK), .DLY_VEC(DLY_VEC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .sleep_go_i (sleep_go),
    .active_o   (active)
  );

  assign act_wide = MAX_CLK'(active);
  assign gate_en  = active;
  assign rd_data  = pack_read(mode, act_wide);

  // R8: hold mode freezes the enables
  assert_hold_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == TC_HOLD) |-> $stable(gate_en));

  // R9: bits 3:2 always read zero
  assert_gap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3:2] == 2'b00);

endmodule

// File: tb/tb_cdtc_top.sv
`timescale 1ns/1ps
module tb_cdtc_top;

  localparam int N_CLK = 3;
  localparam int N_MOD = 4;
  localparam int D0 = 3, D1 = 7, D2 = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [31:0]      wr_data = '0;
  logic [N_MOD-1:0] idle_ack = '0;
  logic [N_MOD-1:0] keep_req = '0;
  logic [N_CLK-1:0] gate_en;
  logic [31:0]      rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cdtc_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .idle_ack(idle_ack), .keep_req(keep_req),
    .gate_en(gate_en), .rd_data(rd_data)
  );

  typedef struct packed {
    logic             wr;
    logic [31:0]      data;
    logic [N_MOD-1:0] ack;
    logic [N_MOD-1:0] keep;
    logic [7:0]       waits;
    logic [31:0]      exp;
    logic [7:0]       req;
  } vec_t;

  // stimulus table, applied from a fresh reset
  localparam vec_t VEC [8] = '{
    '{1'b1, 32'h0000_0002, 4'h0, 4'h0, 8'd12, 32'h0000_0072, 8'd4}, // R4 all on
    '{1'b1, 32'hFFFF_FF8D, 4'h0, 4'h0, 8'd3,  32'h0000_0071, 8'd7}, // R7 ack missing, R3 R9
    '{1'b0, 32'h0,         4'hF, 4'h2, 8'd3,  32'h0000_0071, 8'd7}, // R7 keep held
    '{1'b0, 32'h0,         4'hF, 4'h0, 8'd0,  32'h0000_0001, 8'd6}, // R6 sleep
    '{1'b1, 32'h0000_0003, 4'hF, 4'h0, 8'd2,  32'h0000_0001, 8'd2}, // R2 reserved
    '{1'b1, 32'h0000_0000, 4'h0, 4'h0, 8'd2,  32'h0000_0000, 8'd2}, // R2 hold
    '{1'b1, 32'h0000_0002, 4'h0, 4'h0, 8'd2,  32'h0000_0002, 8'd4}, // R4 early
    '{1'b0, 32'h0,         4'h0, 4'h0, 8'd0,  32'h0000_0012, 8'd4}  // R4 clock0
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; idle_ack = '0; keep_req = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive at negedge, capture at next edge, return at following negedge
  task automatic write(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [2:0] exp_on(input int m);
    return {(m >= D2), (m >= D1), (m >= D0)};
  endfunction

  initial begin
    do_reset();
    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 gate_en", {29'b0, gate_en}, 32'h0);

    for (int k = 0; k < 8; k++) begin
      idle_ack = VEC[k].ack; keep_req = VEC[k].keep;
      wr_en = VEC[k].wr; wr_data = VEC[k].data;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      repeat (int'(VEC[k].waits)) @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[k].req, k), rd_data, VEC[k].exp);
      check($sformatf("R5 vector %0d", k), {29'b0, gate_en}, {29'b0, rd_data[6:4]});
    end

    // R4 R5: cycle-exact rise of each clock
    do_reset();
    write(32'h2);
    for (int m = 1; m <= 13; m++) begin
      @(negedge clk);
      check($sformatf("R4 edge %0d", m), {29'b0, gate_en}, {29'b0, exp_on(m)});
      check($sformatf("R5 edge %0d", m), {29'b0, rd_data[6:4]}, {29'b0, gate_en});
    end

    // R8: wakeup cut short by hold at edge t+5
    do_reset();
    write(32'h2);
    repeat (4) @(negedge clk);
    write(32'h0);
    repeat (10) @(negedge clk);
    check("R8 partial hold", rd_data, 32'h0000_0010);

    // R4 restart: count begins again from the new write
    write(32'h2);
    repeat (6) @(negedge clk);
    check("R4 restart before", {29'b0, gate_en}, 32'h1);
    @(negedge clk);
    check("R4 restart at", {29'b0, gate_en}, 32'h3);

    // R3: status bits not writable
    write(32'h0000_0070);
    repeat (10) @(negedge clk);
    check("R3 status read-only", rd_data, 32'h0000_0030);
    write(32'hFFFF_FF80);
    @(negedge clk);
    check("R3 upper bits ignored", rd_data, 32'h0000_0030);

    // R6 exact timing: acks present, drop one edge after sleep write
    idle_ack = '1;
    write(32'h1);
    check("R6 before qualify edge", rd_data, 32'h0000_0031);
    @(negedge clk);
    check("R6 dropped", rd_data, 32'h0000_0001);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule